// File: doc/BRIEF.md
# Effective Address Micro-Sequencer

This block computes the effective address of a CPU operand and then reads that operand from memory. A one-cycle start pulse supplies three things: an addressing mode, an operand size (byte, word or long) and the value of the base address register. The block has two working registers. The accumulator builds up the address. The operand register collects program words and memory words. Both are visible at the outputs.

Each addressing mode is a short stored microprogram. A micro-PC walks through it one micro-operation at a time, and a length value sets how many steps run. Every micro-operation takes one microcycle of two clock cycles. In the first cycle the block drives any memory or program-word request. In the second cycle it takes in the returned word and updates its registers. For a long operand the microprogram runs two extra microcycles, so the high word is read first and the low word second.

A separate write-back request stores a result for a read-modify-write instruction. It uses the address left in the accumulator by the preceding read.

Top module: `ea_microseq`

## Requirements
- R1: A start pulse while idle raises `busy`, loads `ea_addr` with `base_addr` on the next edge and clears the operand register.
- R2: Every micro-operation lasts two clock cycles, and each memory, fetch or write strobe is high for exactly one cycle. `done` therefore appears 2·L cycles after the start edge. L is the program length: 1, 5, 3 or 4 for modes 0, 1, 2 and 3 with a byte or word operand, and two more for a long operand.
- R3: Mode 0 (register indirect) reads the operand at the base address.
- R4: Mode 1 (indexed) runs these steps in order: idle, fetch an extension word, index add, read, idle; a long operand adds a read and an idle. The extension word has this layout:
  - bit 15 chooses an address (1) or data (0) index register.
  - Bits 14:12 give the register number. `idx_sel` is {bit15, bits14:12}.
  - Bit 11 chooses the full 32-bit index (1) or the sign-extended low 16 bits (0).
  - Bits 7:0 are a signed displacement.
  - The address is base + displacement + index.
- R5: Mode 2 (absolute short) fetches one program word and sign-extends it from 16 to 32 bits into the accumulator.
- R6: Mode 3 (absolute long) fetches two program words, first word high, and moves them into the accumulator.
- R7: `size` is 0 for byte, 1 for word and 2 for long. For a byte, `operand` is the last word read masked to its low 8 bits. For a word it is that word zero-extended. For a long it is {word at EA, word at EA+2}.
- R8: A write-back request while idle writes at the address in `ea_addr`. For a long operand it writes two words, the high half at EA and then the low half at EA+2. For a byte it writes the low 8 bits zero-extended. It then pulses `done`.
- R9: `done` is a one-cycle pulse with `busy` low. Start and write-back requests made while `busy` is high have no effect on the result or on the timing.
- R10: While idle there are no strobes, and `ea_addr` and `operand` hold their values. Reset clears `busy`, `done`, `ea_addr` and `operand`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address calculation and operand read |
| mode | input | 2 | Addressing mode 0..3 |
| size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| base_addr | input | 32 | Base address register value |
| wb_start | input | 1 | Begin a write-back to the last computed address |
| wb_data | input | 32 | Result to write back |
| mem_addr | output | 32 | Memory address for reads and writes |
| mem_rd | output | 1 | Memory read strobe; data is expected one cycle later |
| mem_rdata | input | 16 | Memory read data |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| pf_req | output | 1 | Program-word fetch strobe; the word is expected one cycle later |
| pf_word | input | 16 | Fetched program word |
| idx_sel | output | 4 | Index register select: {address/data, number} |
| idx_val | input | 32 | Selected index register value |
| busy | output | 1 | Sequencer is running |
| done | output | 1 | One-cycle completion pulse |
| ea_addr | output | 32 | Address accumulator |
| operand | output | 32 | Operand register, masked to the operand size |

## Verification
The assertions check properties that hold on every cycle:
- every strobe lasts one cycle;
- reads and writes never overlap;
- no strobe occurs while idle, and the outputs stay stable while idle;
- `done` is a single-cycle pulse outside `busy`;
- the base address is preloaded after a start.

Other behaviour only the bench scenarios can show:
- the address arithmetic of each mode, including sign extension of the displacement, the short index and the absolute short word;
- the byte, word and long masking and the high-word-first order;
- write-back to the leftover address;
- the exact microprogram lengths;
- ignoring starts and write-backs that arrive while the sequencer is busy.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int WORD_W    = 16;
    localparam int LONG_W    = 2 * WORD_W;
    localparam int UPC_W     = 3;
    localparam int SEL_W     = 4;
    localparam int DISP_W    = 8;
    localparam int LONG_XTRA = 2;

    typedef enum logic [2:0] {
        UOP_NOP,
        UOP_RD,
        UOP_PF,
        UOP_XFER,
        UOP_XFER_SX,
        UOP_IDX
    } uop_e;

    typedef enum logic [1:0] {
        AM_IND  = 2'd0,
        AM_IDX  = 2'd1,
        AM_ABSW = 2'd2,
        AM_ABSL = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } opsize_e;

    // Stored microprograms; a long operand runs the same slots two further.
    function automatic uop_e uop_at(input amode_e m, input logic [UPC_W-1:0] slot);
        uop_e u;
        u = UOP_NOP;
        unique case (m)
            AM_IND: begin
                if (slot == 3'd0 || slot == 3'd2) u = UOP_RD;
            end
            AM_IDX: begin
                case (slot)
                    3'd1:       u = UOP_PF;
                    3'd2:       u = UOP_IDX;
                    3'd3, 3'd5: u = UOP_RD;
                    default:    u = UOP_NOP;
                endcase
            end
            AM_ABSW: begin
                case (slot)
                    3'd0:       u = UOP_PF;
                    3'd1:       u = UOP_XFER_SX;
                    3'd2, 3'd4: u = UOP_RD;
                    default:    u = UOP_NOP;
                endcase
            end
            AM_ABSL: begin
                case (slot)
                    3'd0, 3'd1: u = UOP_PF;
                    3'd2:       u = UOP_XFER;
                    3'd3, 3'd5: u = UOP_RD;
                    default:    u = UOP_NOP;
                endcase
            end
            default: u = UOP_NOP;
        endcase
        return u;
    endfunction

    function automatic logic [UPC_W-1:0] short_len(input amode_e m);
        logic [UPC_W-1:0] n;
        unique case (m)
            AM_IND:  n = 3'd1;
            AM_IDX:  n = 3'd5;
            AM_ABSW: n = 3'd3;
            AM_ABSL: n = 3'd4;
            default: n = 3'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ea_uprog_rom.sv
module ea_uprog_rom
    import ea_pkg::*;
(
    input  amode_e            mode_i,
    input  opsize_e           size_i,
    input  logic [UPC_W-1:0]  upc_i,
    output uop_e              uop_o,
    output logic [UPC_W-1:0]  len_o
);
    always_comb begin
        uop_o = uop_at(mode_i, upc_i);
        len_o = short_len(mode_i);
        if (size_i == SZ_LONG) len_o = short_len(mode_i) + UPC_W'(LONG_XTRA);
    end
endmodule

// File: rtl/ea_index_unit.sv
module ea_index_unit
    import ea_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] acc_i,
    input  logic [WORD_W-1:0] ext_i,
    input  logic [ADDR_W-1:0] idx_val_i,
    output logic [SEL_W-1:0]  idx_sel_o,
    output logic [ADDR_W-1:0] sum_o
);
    localparam int DISP_PAD = ADDR_W - DISP_W;
    localparam int IDX_PAD  = ADDR_W - WORD_W;

    logic [ADDR_W-1:0] disp_x;
    logic [ADDR_W-1:0] index_x;

    always_comb begin
        idx_sel_o = {ext_i[15], ext_i[14:12]};
        disp_x    = {{DISP_PAD{ext_i[DISP_W-1]}}, ext_i[DISP_W-1:0]};
        if (ext_i[11]) index_x = idx_val_i;
        else           index_x = {{IDX_PAD{idx_val_i[WORD_W-1]}}, idx_val_i[WORD_W-1:0]};
        sum_o = acc_i + disp_x + index_x;
    end
endmodule

// File: rtl/ea_microseq.sv
module ea_microseq
    import ea_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              wb_start,
    input  logic [LONG_W-1:0] wb_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              pf_req,
    input  logic [WORD_W-1:0] pf_word,
    output logic [SEL_W-1:0]  idx_sel,
    input  logic [ADDR_W-1:0] idx_val,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] ea_addr,
    output logic [LONG_W-1:0] operand
);
    localparam int SX_PAD    = ADDR_W - WORD_W;
    localparam int BYTE_W    = WORD_W / 2;
    localparam int WORD_STEP = WORD_W / 8;

    logic              busy_q, wb_q, phase_q, second_q, done_q;
    logic [UPC_W-1:0]  upc_q, len_q;
    logic [ADDR_W-1:0] acc_q;
    logic [LONG_W-1:0] data_q, wbd_q;
    amode_e            mode_q;
    opsize_e           size_q;

    uop_e              cur_uop;
    logic [UPC_W-1:0]  prog_len, new_len;
    logic [ADDR_W-1:0] idx_sum;
    logic              use_second;

    ea_uprog_rom u_rom (
        .mode_i (amode_e'(start && !busy_q ? mode : mode_q)),
        .size_i (opsize_e'(size)),
        .upc_i  (upc_q),
        .uop_o  (cur_uop),
        .len_o  (prog_len)
    );

    ea_index_unit #(.ADDR_W(ADDR_W)) u_idx (
        .acc_i     (acc_q),
        .ext_i     (data_q[WORD_W-1:0]),
        .idx_val_i (idx_val),
        .idx_sel_o (idx_sel),
        .sum_o     (idx_sum)
    );

    always_comb begin
        new_len    = prog_len;
        use_second = wb_q ? upc_q[0] : second_q;
        mem_addr   = use_second ? acc_q + ADDR_W'(WORD_STEP) : acc_q;
        mem_rd     = busy_q && !wb_q && !phase_q && (cur_uop == UOP_RD);
        pf_req     = busy_q && !wb_q && !phase_q && (cur_uop == UOP_PF);
        mem_wr     = busy_q && wb_q && !phase_q;
        if (size_q == SZ_BYTE)
            mem_wdata = {{(WORD_W-BYTE_W){1'b0}}, wbd_q[BYTE_W-1:0]};
        else if (size_q == SZ_LONG && upc_q == '0)
            mem_wdata = wbd_q[LONG_W-1:WORD_W];
        else
            mem_wdata = wbd_q[WORD_W-1:0];
        unique case (size_q)
            SZ_BYTE: operand = {{(LONG_W-BYTE_W){1'b0}}, data_q[BYTE_W-1:0]};
            SZ_LONG: operand = data_q;
            default: operand = {{(LONG_W-WORD_W){1'b0}}, data_q[WORD_W-1:0]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            wb_q     <= 1'b0;
            phase_q  <= 1'b0;
            second_q <= 1'b0;
            done_q   <= 1'b0;
            upc_q    <= '0;
            len_q    <= '0;
            acc_q    <= '0;
            data_q   <= '0;
            wbd_q    <= '0;
            mode_q   <= AM_IND;
            size_q   <= SZ_WORD;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q   <= 1'b1;
                    wb_q     <= 1'b0;
                    phase_q  <= 1'b0;
                    second_q <= 1'b0;
                    upc_q    <= '0;
                    len_q    <= new_len;
                    acc_q    <= base_addr;
                    data_q   <= '0;
                    mode_q   <= amode_e'(mode);
                    size_q   <= (size == 2'd3) ? SZ_WORD : opsize_e'(size);
                end else if (wb_start) begin
                    busy_q  <= 1'b1;
                    wb_q    <= 1'b1;
                    phase_q <= 1'b0;
                    upc_q   <= '0;
                    len_q   <= (size_q == SZ_LONG) ? UPC_W'(2) : UPC_W'(1);
                    wbd_q   <= wb_data;
                end
            end else if (!phase_q) begin
                phase_q <= 1'b1;
            end else begin
                phase_q <= 1'b0;
                if (!wb_q) begin
                    unique case (cur_uop)
                        UOP_RD: begin
                            data_q   <= {data_q[WORD_W-1:0], mem_rdata};
                            second_q <= 1'b1;
                        end
                        UOP_PF:      data_q <= {data_q[WORD_W-1:0], pf_word};
                        UOP_XFER:    acc_q  <= ADDR_W'(data_q);
                        UOP_XFER_SX: acc_q  <= {{SX_PAD{data_q[WORD_W-1]}}, data_q[WORD_W-1:0]};
                        UOP_IDX:     acc_q  <= idx_sum;
                        default: ;
                    endcase
                end
                upc_q <= upc_q + 1'b1;
                if (upc_q + 1'b1 == len_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign ea_addr = acc_q;
endmodule

// File: rtl/ea_microseq_chk.sv
module ea_microseq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              wb_start,
    input logic [ADDR_W-1:0] base_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              pf_req,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] ea_addr,
    input logic [31:0]       operand
);
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr || pf_req) |=> !(mem_rd || mem_wr || pf_req)); // R2
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9
    AST_ACCESS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr || pf_req) |-> busy); // R10
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && !wb_start) |=> ($stable(ea_addr) && $stable(operand))); // R10
    AST_BASE_PRELOAD: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && ea_addr == $past(base_addr))); // R1
endmodule

bind ea_microseq ea_microseq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .wb_start(wb_start),
    .base_addr(base_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .pf_req(pf_req), .busy(busy), .done(done),
    .ea_addr(ea_addr), .operand(operand)
);

// File: tb/ea_microseq_test.sv
`timescale 1ns/1ps
module ea_microseq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [31:0] base_addr = '0;
    logic        wb_start = 1'b0;
    logic [31:0] wb_data = '0;
    logic [31:0] mem_addr;
    logic        mem_rd, mem_wr, pf_req, busy, done;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem_wdata;
    logic [15:0] pf_word = '0;
    logic [3:0]  idx_sel;
    logic [31:0] idx_val, ea_addr, operand;

    int checks = 0;
    int fails  = 0;
    logic [15:0] pfw [2];
    int pf_ix = 0;
    int wr_n = 0;
    logic [31:0] wr_addr [4];
    logic [15:0] wr_data [4];

    always #2 clk = ~clk;

    ea_microseq uut (.*);

    function automatic logic [15:0] memw(input logic [31:0] a);
        return a[15:0] ^ a[31:16] ^ 16'h5A3C;
    endfunction
    function automatic logic [31:0] idxv(input logic [3:0] s);
        return {12'h000, s, 16'h8000 | {12'h000, s}};
    endfunction
    assign idx_val = idxv(idx_sel);

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= memw(mem_addr);
        if (pf_req) begin
            pf_word <= pfw[pf_ix % 2];
            pf_ix   <= pf_ix + 1;
        end
    end
    always @(negedge clk) if (mem_wr && wr_n < 4) begin
        wr_addr[wr_n] = mem_addr;
        wr_data[wr_n] = mem_wdata;
        wr_n = wr_n + 1;
    end

    typedef struct packed {
        logic [1:0]  m;
        logic [1:0]  s;
        logic [31:0] base;
        logic [15:0] p0;
        logic [15:0] p1;
        logic [3:0]  len;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 2'd1, 32'h0000_1000, 16'h0,    16'h0,    4'd1},
        '{2'd0, 2'd2, 32'h0002_0040, 16'h0,    16'h0,    4'd3},
        '{2'd0, 2'd0, 32'h3000_0010, 16'h0,    16'h0,    4'd1},
        '{2'd1, 2'd1, 32'h0000_4000, 16'h98F0, 16'h0,    4'd5},
        '{2'd1, 2'd2, 32'h0000_4000, 16'h2004, 16'h0,    4'd7},
        '{2'd2, 2'd1, 32'h7777_0000, 16'h8100, 16'h0,    4'd3},
        '{2'd2, 2'd0, 32'h7777_0000, 16'h1234, 16'h0,    4'd3},
        '{2'd3, 2'd2, 32'h0000_0000, 16'h0012, 16'h3456, 4'd6}
    };

    function automatic logic [31:0] ref_ea(input vec_t v);
        logic [31:0] iv, ix;
        case (v.m)
            2'd0: return v.base;
            2'd1: begin
                iv = idxv({v.p0[15], v.p0[14:12]});
                ix = v.p0[11] ? iv : {{16{iv[15]}}, iv[15:0]};
                return v.base + {{24{v.p0[7]}}, v.p0[7:0]} + ix;
            end
            2'd2: return {{16{v.p0[15]}}, v.p0};
            default: return {v.p0, v.p1};
        endcase
    endfunction
    function automatic logic [31:0] ref_op(input logic [31:0] ea, input logic [1:0] s);
        if (s == 2'd2) return {memw(ea), memw(ea + 32'd2)};
        if (s == 2'd0) return {24'h0, memw(ea)[7:0]};
        return {16'h0, memw(ea)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Returns cycle count from the start negedge to the negedge where done is seen.
    task automatic wait_done(input string req, output int cyc);
        cyc = 1;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) check({req, " timeout"}, 32'd0, 32'd1);
    endtask

    task automatic run_vec(input vec_t v, input bit intrude, output int cyc);
        @(negedge clk);
        pfw[0] = v.p0; pfw[1] = v.p1; pf_ix = 0;
        mode = v.m; size = v.s; base_addr = v.base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        if (intrude) begin
            @(negedge clk); cyc++;
            start = 1'b1; wb_start = 1'b1; mode = 2'd0; base_addr = 32'hDEAD_0000; size = 2'd0;
            @(negedge clk); cyc++;
            start = 1'b0; wb_start = 1'b0;
        end
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        vec_t v;
        logic [31:0] ea;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 reset busy", {31'd0, busy}, 32'd0);
        check("R10 reset done", {31'd0, done}, 32'd0);
        check("R10 reset ea_addr", ea_addr, 32'd0);
        check("R10 reset operand", operand, 32'd0);

        // R3 R4 R5 R6 R7 R2: table walk
        foreach (VECS[i]) begin
            v = VECS[i];
            run_vec(v, 1'b0, cyc);
            ea = ref_ea(v);
            check($sformatf("R2 len vec%0d", i), cyc, 2 * v.len + 1);
            check($sformatf("R4 R5 R6 ea vec%0d", i), ea_addr, ea);
            check($sformatf("R3 R7 operand vec%0d", i), operand, ref_op(ea, v.s));
            @(negedge clk);
            check($sformatf("R9 done pulse vec%0d", i), {31'd0, done}, 32'd0);
        end

        // R10: idle hold with no requests
        repeat (5) @(negedge clk);
        check("R10 idle ea hold", ea_addr, ref_ea(VECS[7]));
        check("R10 idle strobes", {29'd0, mem_rd, mem_wr, pf_req}, 32'd0);

        // R8: long write-back after a long read
        wr_n = 0;
        @(negedge clk);
        wb_data = 32'hCAFE_F00D; wb_start = 1'b1;
        @(negedge clk);
        wb_start = 1'b0;
        wait_done("R8", cyc);
        check("R8 wb long cycles", cyc, 32'd5);
        check("R8 wb count", wr_n, 32'd2);
        check("R8 wb addr hi", wr_addr[0], ref_ea(VECS[7]));
        check("R8 wb data hi", {16'h0, wr_data[0]}, 32'h0000_CAFE);
        check("R8 wb addr lo", wr_addr[1], ref_ea(VECS[7]) + 32'd2);
        check("R8 wb data lo", {16'h0, wr_data[1]}, 32'h0000_F00D);

        // R8: byte write-back
        run_vec(VECS[2], 1'b0, cyc);
        wr_n = 0;
        @(negedge clk);
        wb_data = 32'h1234_56A7; wb_start = 1'b1;
        @(negedge clk);
        wb_start = 1'b0;
        wait_done("R8", cyc);
        check("R8 wb byte count", wr_n, 32'd1);
        check("R8 wb byte addr", wr_addr[0], 32'h3000_0010);
        check("R8 wb byte data", {16'h0, wr_data[0]}, 32'h0000_00A7);

        // R9: start and write-back while busy are ignored
        wr_n = 0;
        run_vec(VECS[4], 1'b1, cyc);
        check("R9 ignored len", cyc, 32'd15);
        check("R9 ignored ea", ea_addr, ref_ea(VECS[4]));
        check("R9 ignored operand", operand, ref_op(ref_ea(VECS[4]), 2'd2));
        check("R9 ignored no write", wr_n, 32'd0);
        repeat (3) @(negedge clk);
        check("R9 no later run", {31'd0, busy}, 32'd0);

        // R1: preload visible one edge after start
        @(negedge clk);
        mode = 2'd1; size = 2'd1; base_addr = 32'h0ABC_0000; pfw[0] = 16'h0; pf_ix = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1 preload", ea_addr, 32'h0ABC_0000);
        check("R1 busy", {31'd0, busy}, 32'd1);
        check("R1 operand cleared", operand, 32'd0);
        // R10: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset mid-run busy", {31'd0, busy}, 32'd0);
        check("R10 reset mid-run ea", ea_addr, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule